// File: doc/BRIEF.md
# Memory Access Slot Alignment Unit

This block sits beside an 8-bit CPU and forces every memory access to begin on a fixed timing slot. With a 4 MHz CPU clock, a slot lasts 1 microsecond, which is four CPU clocks. A free-running phase counter marks where each slot starts: phase 0 is a slot boundary. When the CPU starts an opcode fetch, a memory read or a memory write at any other phase, the block raises its hold request. The request stays high until the counter comes back to phase 0. The result is that every instruction is rounded up to whole slots.

Interrupt acknowledge cycles are treated differently. Some instructions finish their internal work before the slot ends, which leaves unused clocks before the next boundary. An acknowledge that arrives while enough of that slack remains starts at once, with no hold. For that reason the interrupt seems to arrive earlier after such instructions. If too little slack is left, the acknowledge is held to the next boundary, exactly like a memory access. An acknowledge that lands on the boundary itself takes its own slot-aligned cycle.

Each bus status input is a one-clock strobe in the first clock of the CPU's machine cycle. At most one of them is high at a time, and none is raised while the hold request is high. The hold output is combinational, so the CPU sees it in the same clock in which it samples it.

Top module: `slot_align_unit`

## Requirements
- R1: While reset is asserted and right after it, the phase output is 0 and the hold request is low.
- R2: Once out of reset, the phase advances by one on every clock and wraps from 3 back to 0.
- R3: A fetch, read or write strobe at phase 0 raises no hold.
- R4: A fetch, read or write strobe at phase p (1 to 3) raises the hold in the strobe clock. The hold stays high in every following clock until phase 0, so there are exactly 4-p hold clocks, and it is low at phase 0.
- R5: Fetch, read and write strobes produce the same hold count for the same phase.
- R6: An interrupt acknowledge strobe at phase 1 or 2 falls inside slack of at least 2 clocks. It starts immediately and raises no hold.
- R7: An interrupt acknowledge strobe at phase 3 leaves only 1 clock of slack, which is below the minimum of 2. It is held until the next boundary, for 1 hold clock.
- R8: An interrupt acknowledge strobe at phase 0 takes its own aligned slot and raises no hold.
- R9: The hold request is never high at phase 0.
- R10: The hold request never rises without a strobe. With no strobes, it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock (4 clocks per slot) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_i | input | 1 | Opcode-fetch cycle start strobe |
| mem_rd_i | input | 1 | Memory-read cycle start strobe |
| mem_wr_i | input | 1 | Memory-write cycle start strobe |
| int_ack_i | input | 1 | Interrupt-acknowledge cycle start strobe |
| wait_o | output | 1 | Hold request to the CPU (combinational) |
| slot_phase_o | output | 2 | Current phase within the slot, 0 = boundary |

## Verification
On every clock, the bound checker confirms several invariants. The phase steps by one and wraps. The hold request is never high at a boundary. A hold that has started is not dropped before the boundary. The hold never appears without either a strobe or a hold in the previous clock. Boundary strobes and acknowledges that fall inside enough slack raise no hold. The bench's directed scenarios are needed for the rest. They show the exact number of hold clocks for each kind of strobe at each phase, including the slack threshold that separates an early acknowledge from a held one, as well as the reset state and long idle stretches.

// File: rtl/slot_align_pkg.sv
package slot_align_pkg;
    // Class of bus cycle that a strobe announces
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_MEM  = 2'd1,
        ACC_IACK = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/slot_phase_ctr.sv
module slot_phase_ctr #(
    parameter int SLOT_CYCLES = 4,
    localparam int PHASE_W = $clog2(SLOT_CYCLES)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PHASE_W-1:0] phase_o,
    output logic               last_o
);
    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(SLOT_CYCLES - 1);

    logic [PHASE_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign phase_o = phase_q;
    assign last_o  = (phase_q == LAST);
endmodule

// File: rtl/slot_req_decode.sv
module slot_req_decode
    import slot_align_pkg::*;
(
    input  logic      fetch_i,
    input  logic      mem_rd_i,
    input  logic      mem_wr_i,
    input  logic      int_ack_i,
    output acc_kind_e kind_o
);
    always_comb begin
        if (int_ack_i)                          kind_o = ACC_IACK;
        else if (fetch_i | mem_rd_i | mem_wr_i) kind_o = ACC_MEM;
        else                                    kind_o = ACC_NONE;
    end
endmodule

// File: rtl/slot_hold_ctrl.sv
module slot_hold_ctrl
    import slot_align_pkg::*;
#(
    parameter int SLOT_CYCLES    = 4,
    parameter int IACK_MIN_SLACK = 2,
    localparam int PHASE_W = $clog2(SLOT_CYCLES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  acc_kind_e          kind_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               last_i,
    output logic               wait_o
);
    typedef struct packed {
        logic pend;
    } hold_state_t;

    hold_state_t st_d, st_q;
    logic off_bound;
    logic short_slack;
    logic hold_now;

    always_comb begin
        off_bound   = (phase_i != '0);
        // clocks left before the next boundary, compared with the minimum
        short_slack = (SLOT_CYCLES - int'(phase_i)) < IACK_MIN_SLACK;
        hold_now    = off_bound &&
                      ((kind_i == ACC_MEM) ||
                       (kind_i == ACC_IACK && short_slack));
        wait_o      = off_bound && (hold_now || st_q.pend);
        st_d.pend   = (hold_now || st_q.pend) && !last_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/slot_align_unit.sv
module slot_align_unit
    import slot_align_pkg::*;
#(
    parameter int SLOT_CYCLES    = 4,
    parameter int IACK_MIN_SLACK = 2,
    localparam int PHASE_W = $clog2(SLOT_CYCLES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_i,
    input  logic               mem_rd_i,
    input  logic               mem_wr_i,
    input  logic               int_ack_i,
    output logic               wait_o,
    output logic [PHASE_W-1:0] slot_phase_o
);
    acc_kind_e          kind;
    logic [PHASE_W-1:0] phase;
    logic               last;

    slot_phase_ctr #(.SLOT_CYCLES(SLOT_CYCLES)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase),
        .last_o  (last)
    );

    slot_req_decode u_dec (
        .fetch_i   (fetch_i),
        .mem_rd_i  (mem_rd_i),
        .mem_wr_i  (mem_wr_i),
        .int_ack_i (int_ack_i),
        .kind_o    (kind)
    );

    slot_hold_ctrl #(
        .SLOT_CYCLES    (SLOT_CYCLES),
        .IACK_MIN_SLACK (IACK_MIN_SLACK)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind_i  (kind),
        .phase_i (phase),
        .last_i  (last),
        .wait_o  (wait_o)
    );

    assign slot_phase_o = phase;
endmodule

// File: rtl/slot_align_chk.sv
module slot_align_chk #(
    parameter int SLOT_CYCLES    = 4,
    parameter int IACK_MIN_SLACK = 2,
    localparam int PHASE_W = $clog2(SLOT_CYCLES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_i,
    input logic               mem_rd_i,
    input logic               mem_wr_i,
    input logic               int_ack_i,
    input logic               wait_o,
    input logic [PHASE_W-1:0] slot_phase_o
);
    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(SLOT_CYCLES - 1);

    logic seen_q;
    logic mem_stb;
    logic any_stb;
    logic roomy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assign mem_stb = fetch_i | mem_rd_i | mem_wr_i;
    assign any_stb = mem_stb | int_ack_i;
    assign roomy   = (SLOT_CYCLES - int'(slot_phase_o)) >= IACK_MIN_SLACK;

    // R1
    always_comb begin
        if (!rst_n) rst_idle_chk: assert (slot_phase_o == '0 && !wait_o);
    end

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> slot_phase_o == (($past(slot_phase_o) == LAST) ? '0
                                     : $past(slot_phase_o) + 1'b1));

    // R3
    bound_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && slot_phase_o == '0) |-> !wait_o);

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_o && slot_phase_o != LAST) |=> wait_o);

    // R6
    iack_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack_i && slot_phase_o != '0 && roomy) |-> !wait_o);

    // R8
    iack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack_i && slot_phase_o == '0) |-> !wait_o);

    // R9
    no_bound_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_phase_o == '0) |-> !wait_o);

    // R10
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && wait_o && !any_stb) |-> $past(wait_o));
endmodule

bind slot_align_unit slot_align_chk #(
    .SLOT_CYCLES    (SLOT_CYCLES),
    .IACK_MIN_SLACK (IACK_MIN_SLACK)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_i      (fetch_i),
    .mem_rd_i     (mem_rd_i),
    .mem_wr_i     (mem_wr_i),
    .int_ack_i    (int_ack_i),
    .wait_o       (wait_o),
    .slot_phase_o (slot_phase_o)
);

// File: tb/slot_align_unit_tb.sv
module slot_align_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_i = 1'b0, mem_rd_i = 1'b0, mem_wr_i = 1'b0, int_ack_i = 1'b0;
    logic       wait_o;
    logic [1:0] slot_phase_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    slot_align_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_i      (fetch_i),
        .mem_rd_i     (mem_rd_i),
        .mem_wr_i     (mem_wr_i),
        .int_ack_i    (int_ack_i),
        .wait_o       (wait_o),
        .slot_phase_o (slot_phase_o)
    );

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // kind: 0 fetch, 1 read, 2 write, 3 interrupt acknowledge
    task automatic strobe_count(int kind, int p, output int holds);
        holds = 0;
        @(negedge clk);
        while (int'(slot_phase_o) != p) @(negedge clk);
        fetch_i   = (kind == 0);
        mem_rd_i  = (kind == 1);
        mem_wr_i  = (kind == 2);
        int_ack_i = (kind == 3);
        #1;
        if (wait_o) holds++;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            fetch_i = 1'b0; mem_rd_i = 1'b0; mem_wr_i = 1'b0; int_ack_i = 1'b0;
            #1;
            if (wait_o) holds++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 phase in reset", int'(slot_phase_o), 0);
        check("R1 wait in reset", int'(wait_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 phase after reset", int'(slot_phase_o), 1);
    endtask

    task automatic t_phase_walk();
        int prev = int'(slot_phase_o);
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            check("R2 phase step", int'(slot_phase_o), (prev + 1) % 4);
            prev = int'(slot_phase_o);
        end
    endtask

    task automatic t_mem();
        int h;
        for (int kind = 0; kind < 3; kind++)
            for (int p = 0; p < 4; p++) begin
                strobe_count(kind, p, h);
                if (p == 0) check("R3 boundary access", h, 0);
                else        check("R4 R5 off-boundary access", h, 4 - p);
            end
    endtask

    task automatic t_iack();
        int h;
        for (int p = 0; p < 4; p++) begin
            strobe_count(3, p, h);
            if (p == 0)          check("R8 acknowledge on boundary", h, 0);
            else if (4 - p >= 2) check("R6 acknowledge in slack", h, 0);
            else                 check("R7 acknowledge short slack", h, 4 - p);
        end
    endtask

    task automatic t_idle();
        int h = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (wait_o) h++;
            if (slot_phase_o == 2'd0) check("R9 no wait at boundary", int'(wait_o), 0);
        end
        check("R10 idle holds", h, 0);
    endtask

    task automatic t_sequence();
        int h;
        // fetch at boundary, then slack acknowledge, then a late write
        strobe_count(0, 0, h); check("R3 seq fetch", h, 0);
        strobe_count(3, 2, h); check("R6 seq acknowledge", h, 0);
        strobe_count(2, 1, h); check("R4 seq write", h, 3);
        strobe_count(3, 3, h); check("R7 seq acknowledge", h, 1);
    endtask

    initial begin
        t_reset();
        t_phase_walk();
        t_mem();
        t_iack();
        t_idle();
        t_sequence();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule